// File: doc/BRIEF.md
# Bitmap Packet Identifier Filter

This block screens a byte-wide packet stream and lets each packet through or removes it, based on an identifier taken from the packet's leading bytes. Each input byte comes with a valid strobe and start and end markers. Up to eight leading bytes are packed into a 64-bit word, with the earliest byte in the top byte lane. A slice of that word, whose low bit position and width are configuration inputs, forms the identifier. The identifier selects one bit in an internal 8192-entry table. A set bit forwards the packet and a clear bit discards it.

Bytes are held in a packet buffer until the verdict for their packet exists, so a packet leaves either whole or not at all. The table is loaded one byte at a time through a host write port. Writes are queued and are only committed while no packet header is being evaluated. A global enable input turns filtering off, and then every packet passes.

Top module: `pidf_packet_filter`

## Requirements
- R1: After reset the output valid is low and the table is all zero, so with filtering enabled every packet is dropped until bits are set.
- R2: The identifier is bits [off + width - 1 : off] of a 64-bit word in which packet byte 0 occupies bits 63:56, byte 1 bits 55:48, and so on up to byte 7 in bits 7:0. With off = 40 and width = 13, the identifier is {byte1[4:0], byte2}.
- R3: Identifier n is table byte n >> 3, bit n & 7, where bit 0 is the least significant. A host write replaces the whole addressed byte.
- R4: A packet whose table bit is 1 is output complete, in its original byte order, with its start and end markers on its first and last bytes.
- R5: A packet whose table bit is 0 produces no output bytes at all.
- R6: With the filter enable low, every packet passes regardless of the table.
- R7: With every table byte written to zero and the filter enabled, every packet is dropped.
- R8: Other offset and width settings select other slices. For example, off = 0 with width = 8 makes byte 7 the identifier.
- R9: A packet that ends before its eighth byte is judged at its last byte, with the missing bytes taken as zero.
- R10: A table write accepted two or more cycles before a packet's first byte applies to that packet. A write accepted after the packet's first byte and before its verdict does not apply to it, but does apply to the next packet.
- R11: Idle cycles between the bytes of a packet do not change what is output.
- R12: No internal queue overflows or underflows, provided no more than the write-queue depth of host writes arrive while one header is being evaluated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| filt_en_i | input | 1 | Filter enable; low passes every packet |
| pid_off_i | input | 6 | Bit position of the identifier's low bit within the 64-bit header word |
| pid_bits_i | input | 4 | Identifier width in bits; values above 13 act as 13 |
| tbl_we_i | input | 1 | Table byte write strobe |
| tbl_addr_i | input | 10 | Table byte address (identifier >> 3) |
| tbl_data_i | input | 8 | Table byte value; bit k covers identifier 8*addr + k |
| in_valid_i | input | 1 | Input byte valid |
| in_data_i | input | 8 | Input byte |
| in_sop_i | input | 1 | Marks the first byte of a packet |
| in_eop_i | input | 1 | Marks the last byte of a packet |
| out_valid_o | output | 1 | Output byte valid |
| out_data_o | output | 8 | Output byte |
| out_sop_o | output | 1 | Marks the first byte of a forwarded packet |
| out_eop_o | output | 1 | Marks the last byte of a forwarded packet |

## Verification
The hardest situation to reach is a table write that lands inside the short window between a packet's first byte and its verdict. The bench forks a host write three cycles after the first byte of a 20-byte packet, so it falls before the eighth byte, and targets the very bit that packet looks up. The packet must vanish and an identical follow-up packet must pass. Short packets, a relocated identifier slice and byte streams with idle gaps are also driven, and each forwarded byte is compared against a table model kept in the bench.

// File: rtl/pidf_pkg.sv
package pidf_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned HDR_BYTES = 8;
  localparam int unsigned WORD_W    = BYTE_W * HDR_BYTES;

  typedef struct packed {
    logic              sop;
    logic              eop;
    logic [BYTE_W-1:0] data;
  } beat_t;
endpackage

// File: rtl/pidf_fifo.sv
module pidf_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [AW:0]   cnt_q;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == (AW+1)'(DEPTH));
  assign rdata_o = mem[rptr_q];

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_i) wptr_q <= (wptr_q == AW'(DEPTH-1)) ? '0 : wptr_q + 1'b1;
      if (pop_i)  rptr_q <= (rptr_q == AW'(DEPTH-1)) ? '0 : rptr_q + 1'b1;
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assert_no_overflow_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (!full_o || pop_i));
  assert_no_underflow_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/pidf_hdr_extract.sv
module pidf_hdr_extract
  import pidf_pkg::*;
#(
  parameter int unsigned PID_W = 13,
  parameter int unsigned OFF_W = 6,
  parameter int unsigned NB_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              sop_i,
  input  logic              eop_i,
  input  logic [OFF_W-1:0]  cfg_off_i,
  input  logic [NB_W-1:0]   cfg_bits_i,
  output logic              busy_o,
  output logic              lookup_o,
  output logic [PID_W-1:0]  pid_o
);
  logic              open_q;
  logic [2:0]        cnt_q;
  logic [WORD_W-1:0] word_q, word_d, word_sh;
  logic              start, active;
  logic [2:0]        idx;
  logic [PID_W-1:0]  mask;

  assign start  = valid_i & sop_i;
  assign active = start | open_q;
  assign idx    = start ? 3'd0 : cnt_q;
  assign busy_o = active;

  // earliest byte lands in the top lane; unseen bytes stay zero
  always_comb begin
    word_d = start ? '0 : word_q;
    if (valid_i && active)
      word_d[(HDR_BYTES-1-idx)*BYTE_W +: BYTE_W] = data_i;
  end

  assign lookup_o = valid_i & active & ((idx == 3'(HDR_BYTES-1)) | eop_i);

  always_comb begin
    if (cfg_bits_i >= NB_W'(PID_W)) mask = '1;
    else                            mask = (PID_W'(1) << cfg_bits_i) - 1'b1;
  end

  assign word_sh = word_d >> cfg_off_i;
  assign pid_o   = PID_W'(word_sh) & mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
      word_q <= '0;
    end else if (valid_i && active) begin
      word_q <= word_d;
      if (lookup_o) begin
        open_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        open_q <= 1'b1;
        cnt_q  <= idx + 1'b1;
      end
    end
  end

  assert_hdr_idx_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    open_q |-> (cnt_q != 3'd0));
endmodule

// File: rtl/pidf_bitmap.sv
module pidf_bitmap #(
  parameter int unsigned PID_W      = 13,
  parameter int unsigned PEND_DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [PID_W-4:0] waddr_i,
  input  logic [7:0]       wdata_i,
  input  logic             busy_i,
  input  logic [PID_W-1:0] rd_pid_i,
  output logic             rd_bit_o
);
  localparam int unsigned AB      = PID_W - 3;
  localparam int unsigned ENTRIES = 1 << AB;
  localparam int unsigned QW      = AB + 8;

  logic [7:0]    tbl_q [ENTRIES];
  logic [QW-1:0] q_head;
  logic          q_empty, q_full, drain;

  // writes wait while a header verdict is pending
  pidf_fifo #(.W(QW), .DEPTH(PEND_DEPTH)) u_wq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (wr_i),
    .wdata_i ({waddr_i, wdata_i}),
    .pop_i   (drain),
    .rdata_o (q_head),
    .empty_o (q_empty),
    .full_o  (q_full)
  );

  assign drain = !q_empty && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) tbl_q[i] <= '0;
    end else if (drain) begin
      tbl_q[q_head[QW-1:8]] <= q_head[7:0];
    end
  end

  assign rd_bit_o = tbl_q[rd_pid_i[PID_W-1:3]][rd_pid_i[2:0]];

  assert_wq_room_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_full && busy_i) |-> !wr_i);
endmodule

// File: rtl/pidf_packet_filter.sv
module pidf_packet_filter
  import pidf_pkg::*;
#(
  parameter int unsigned PID_W      = 13,
  parameter int unsigned OFF_W      = 6,
  parameter int unsigned NB_W       = 4,
  parameter int unsigned BUF_DEPTH  = 32,
  parameter int unsigned DEC_DEPTH  = 8,
  parameter int unsigned PEND_DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             filt_en_i,
  input  logic [OFF_W-1:0] pid_off_i,
  input  logic [NB_W-1:0]  pid_bits_i,
  input  logic             tbl_we_i,
  input  logic [PID_W-4:0] tbl_addr_i,
  input  logic [7:0]       tbl_data_i,
  input  logic             in_valid_i,
  input  logic [7:0]       in_data_i,
  input  logic             in_sop_i,
  input  logic             in_eop_i,
  output logic             out_valid_o,
  output logic [7:0]       out_data_o,
  output logic             out_sop_o,
  output logic             out_eop_o
);
  localparam int unsigned BEAT_W = $bits(beat_t);

  logic             hdr_busy, lookup;
  logic [PID_W-1:0] pid;
  logic             tbl_bit, verdict;
  beat_t            in_beat, head_beat;
  logic             buf_empty, buf_full, dec_empty, dec_full, dec_head;
  logic             pop_beat, pop_dec;

  pidf_hdr_extract #(.PID_W(PID_W), .OFF_W(OFF_W), .NB_W(NB_W)) u_hdr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (in_valid_i),
    .data_i     (in_data_i),
    .sop_i      (in_sop_i),
    .eop_i      (in_eop_i),
    .cfg_off_i  (pid_off_i),
    .cfg_bits_i (pid_bits_i),
    .busy_o     (hdr_busy),
    .lookup_o   (lookup),
    .pid_o      (pid)
  );

  pidf_bitmap #(.PID_W(PID_W), .PEND_DEPTH(PEND_DEPTH)) u_tbl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (tbl_we_i),
    .waddr_i  (tbl_addr_i),
    .wdata_i  (tbl_data_i),
    .busy_i   (hdr_busy),
    .rd_pid_i (pid),
    .rd_bit_o (tbl_bit)
  );

  assign verdict = !filt_en_i || tbl_bit;
  assign in_beat = '{sop: in_sop_i, eop: in_eop_i, data: in_data_i};

  pidf_fifo #(.W(BEAT_W), .DEPTH(BUF_DEPTH)) u_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (in_valid_i),
    .wdata_i (in_beat),
    .pop_i   (pop_beat),
    .rdata_o (head_beat),
    .empty_o (buf_empty),
    .full_o  (buf_full)
  );

  pidf_fifo #(.W(1), .DEPTH(DEC_DEPTH)) u_dec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (lookup),
    .wdata_i (verdict),
    .pop_i   (pop_dec),
    .rdata_o (dec_head),
    .empty_o (dec_empty),
    .full_o  (dec_full)
  );

  // head packet drains once its verdict is queued
  assign pop_beat = !buf_empty && !dec_empty;
  assign pop_dec  = pop_beat && head_beat.eop;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
      out_sop_o   <= 1'b0;
      out_eop_o   <= 1'b0;
    end else begin
      out_valid_o <= pop_beat && dec_head;
      out_data_o  <= head_beat.data;
      out_sop_o   <= head_beat.sop;
      out_eop_o   <= head_beat.eop;
    end
  end

  // output framing tracker for the checks below
  logic out_open_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_open_q <= 1'b0;
    else if (out_valid_o) out_open_q <= !out_eop_o;
  end

  assert_sop_framing_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_sop_o) |-> !out_open_q);
  assert_eop_framing_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_open_q) |-> out_sop_o);
  assert_buf_room_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_full |-> !in_valid_i || pop_beat);
  assert_dec_room_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_full |-> !lookup || pop_dec);
endmodule

// File: tb/pidf_packet_filter_tb_top.sv
module pidf_packet_filter_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       filt_en = 1'b1;
  logic [5:0] off = 6'd40;
  logic [3:0] nbits = 4'd13;
  logic       we = 1'b0;
  logic [9:0] waddr = '0;
  logic [7:0] wdata = '0;
  logic       iv = 1'b0, isop = 1'b0, ieop = 1'b0;
  logic [7:0] id = '0;
  logic       ov, osop, oeop;
  logic [7:0] od;

  always #2 clk = ~clk;

  pidf_packet_filter dut_i (
    .clk_i(clk), .rst_ni(rst_n), .filt_en_i(filt_en), .pid_off_i(off),
    .pid_bits_i(nbits), .tbl_we_i(we), .tbl_addr_i(waddr), .tbl_data_i(wdata),
    .in_valid_i(iv), .in_data_i(id), .in_sop_i(isop), .in_eop_i(ieop),
    .out_valid_o(ov), .out_data_o(od), .out_sop_o(osop), .out_eop_o(oeop)
  );

  int         n_chk = 0, n_err = 0;
  bit         done = 1'b0;
  string      cur_req = "R1";
  logic [7:0] tbl_m [1024];
  logic [7:0] pkt [32];
  logic [9:0] exp_q [$];

  // {pid, set bit, expected pass}
  localparam logic [14:0] VEC [8] = '{
    {13'h0000, 1'b1, 1'b1}, {13'h0007, 1'b1, 1'b1}, {13'h0008, 1'b1, 1'b1},
    {13'h0009, 1'b0, 1'b0}, {13'h1FFF, 1'b1, 1'b1}, {13'h1FFE, 1'b0, 1'b0},
    {13'h0100, 1'b1, 1'b1}, {13'h0001, 1'b0, 1'b0}
  };

  always @(negedge clk) begin
    if (rst_n && ov) begin
      logic [9:0] got, e;
      got = {osop, oeop, od};
      n_chk++;
      if (exp_q.size() == 0) begin
        n_err++;
        $display("FAIL %s unexpected output got %h expected none", cur_req, got);
      end else begin
        e = exp_q.pop_front();
        if (got !== e) begin
          n_err++;
          $display("FAIL %s output got %h expected %h", cur_req, got, e);
        end
      end
    end
  end

  task automatic hwr(input logic [9:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; waddr = a; wdata = d; tbl_m[a] = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic set_bit(input logic [12:0] pid, input logic v);
    logic [7:0] b;
    b = tbl_m[pid[12:3]];
    b[pid[2:0]] = v;
    hwr(pid[12:3], b);
  endtask

  task automatic fill_pkt(input logic [12:0] pid, input int len);
    for (int k = 0; k < len; k++) pkt[k] = 8'(k * 13 + 5);
    pkt[0] = 8'h47; pkt[1] = {3'b0, pid[12:8]}; pkt[2] = pid[7:0];
  endtask

  function automatic bit model_pass(input int len);
    logic [63:0] w;
    logic [12:0] p, m;
    w = '0;
    for (int k = 0; k < 8; k++) if (k < len) w[63-8*k -: 8] = pkt[k];
    m = (nbits >= 4'd13) ? 13'h1FFF : 13'((1 << nbits) - 1);
    p = 13'(w >> off) & m;
    return !filt_en || tbl_m[p[12:3]][p[2:0]];
  endfunction

  task automatic send(input int len, input int gap, input bit pass);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      iv = 1'b1; id = pkt[k]; isop = (k == 0); ieop = (k == len - 1);
      if (pass) exp_q.push_back({isop, ieop, id});
      if (gap > 0 && k < len - 1) begin
        @(negedge clk); iv = 1'b0;
        repeat (gap - 1) @(negedge clk);
      end
    end
    @(negedge clk); iv = 1'b0; isop = 1'b0; ieop = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic drain_check(input string req);
    repeat (40) @(negedge clk);
    n_chk++;
    if (exp_q.size() != 0) begin
      n_err++;
      $display("FAIL %s missing bytes got %0d left expected 0", req, exp_q.size());
      exp_q.delete();
    end
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) tbl_m[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: idle output and empty table after reset
    repeat (2) @(negedge clk);
    n_chk++;
    if (ov !== 1'b0) begin n_err++; $display("FAIL R1 out_valid got %b expected 0", ov); end
    fill_pkt(13'h0042, 10); send(10, 0, 1'b0);
    drain_check("R1");

    // R2 R3 R4 R5 vectors, then again with gaps for R11
    cur_req = "R3";
    for (int v = 0; v < 8; v++) set_bit(VEC[v][14:2], VEC[v][1]);
    for (int r = 0; r < 2; r++) begin
      cur_req = (r == 0) ? "R4" : "R11";
      for (int v = 0; v < 8; v++) begin
        fill_pkt(VEC[v][14:2], 12);
        send(12, r * 2, VEC[v][0]);
      end
      drain_check(cur_req);
    end

    // R6: bypass passes unset identifiers
    cur_req = "R6"; filt_en = 1'b0;
    fill_pkt(13'h0009, 9);  send(9, 0, 1'b1);
    fill_pkt(13'h1234, 15); send(15, 1, 1'b1);
    drain_check("R6");
    filt_en = 1'b1;

    // R9: short packets, missing bytes are zero
    cur_req = "R9";
    set_bit(13'h0500, 1'b1);
    fill_pkt(13'h0500, 2); send(2, 0, model_pass(2));
    fill_pkt(13'h0600, 2); send(2, 0, model_pass(2));
    fill_pkt(13'h0500, 1); pkt[0] = 8'h00; send(1, 0, model_pass(1));
    drain_check("R9");

    // R8: identifier is byte 7
    cur_req = "R8"; off = 6'd0; nbits = 4'd8;
    set_bit(13'h0025, 1'b1);
    fill_pkt(13'h0000, 10); pkt[7] = 8'h25; send(10, 0, model_pass(10));
    fill_pkt(13'h0000, 10); pkt[7] = 8'h26; send(10, 0, model_pass(10));
    drain_check("R8");
    off = 6'd40; nbits = 4'd13;

    // R10: write in the header window affects only the next packet
    cur_req = "R10";
    set_bit(13'h0123, 1'b0);
    fill_pkt(13'h0123, 20);
    fork
      send(20, 0, 1'b0);
      begin repeat (3) @(negedge clk); set_bit(13'h0123, 1'b1); end
    join
    fill_pkt(13'h0123, 20); send(20, 0, 1'b1);
    drain_check("R10");

    // R7: cleared table blocks everything
    cur_req = "R7";
    for (int i = 0; i < 1024; i++) hwr(10'(i), 8'h00);
    for (int v = 0; v < 8; v++) begin
      fill_pkt(VEC[v][14:2], 10);
      send(10, 0, 1'b0);
    end
    drain_check("R7");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog run hung got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule